// File: doc/BRIEF.md
# Descriptor-Chain DMA Channel

This block is one DMA channel that works through a chain of buffer descriptors stored in a local descriptor RAM. Software fills in descriptors and links them through their next pointers. It sets the hardware-owned flag in each one, then writes the address of the first descriptor to the head pointer register. For each descriptor the channel reads the four words and checks that it owns the descriptor. It then issues one byte beat per byte of the buffer on a valid/ready stream port. Each beat carries the byte's address together with start-of-packet and end-of-packet marks.

After the last beat the channel rewrites the descriptor's mode word. The rewritten word has ownership cleared, the transferred length in its low bits, and the end-of-queue flag set if the chain ended there. The channel also records that descriptor in the completion register. Software appends to a running chain by writing the old tail's next pointer. If it then finds the end-of-queue flag set on the old tail, it restarts the channel by writing the head pointer again.

The controller is a four-state machine with states IDLE, LOAD, XFER and WBACK, and these transitions:
- IDLE to LOAD when a head write starts the channel.
- LOAD to XFER when the descriptor is owned and has a nonzero length.
- LOAD to WBACK when the descriptor is owned and has zero length.
- LOAD to IDLE when the descriptor is not owned.
- XFER to WBACK when the last beat is accepted.
- WBACK to LOAD when the next pointer is nonzero and the channel is enabled.
- WBACK to IDLE otherwise.
- Any state to IDLE on a soft reset.

WBACK holds for a cycle in which the host writes the descriptor RAM.

Top module: `bdq_dma_chan`

## Requirements
- R1: A descriptor at byte offset P in the descriptor RAM occupies four words: the next pointer at P, the buffer address at P+4, the length at P+8 (low 11 bits used), and the mode word at P+12. The host reaches RAM word P/4 at host address 0x800+P. P must be a multiple of 16, and a next pointer of 0 means the chain ends.
- R2: The host registers use word offsets from 0x000. Offset 0x000 is control, where bit 0 is enable. Offset 0x004 is soft reset (bit 0). Offset 0x008 is the head pointer, offset 0x00C is the completion pointer, and offset 0x010 is status, where bit 0 is the sticky mismatch flag and bit 1 is busy. All registers read 0 after reset.
- R3: A nonzero write to the head pointer while the channel is idle and enabled starts it at that descriptor. The head pointer then reads back the descriptor in progress. Head writes made while busy or while disabled are ignored, and the head pointer reads 0 whenever the channel is idle.
- R4: A descriptor whose mode bit 29 (owned) is clear is neither transferred nor rewritten, and the channel goes idle.
- R5: For an owned descriptor of length L the channel gives L beats, with addresses buffer+0 through buffer+L-1. The first beat carries start-of-packet when mode bit 31 is set, and the last beat carries end-of-packet when mode bit 30 is set. L=0 gives no beats.
- R6: While a beat is offered and not accepted, the valid signal, the address and both marks stay unchanged.
- R7: On completion the mode word is rewritten as follows: bits 31, 30 and 27..11 are kept, bit 29 is cleared, bits 10..0 hold L, and bit 28 (end of queue) is set exactly when the next pointer read at completion is 0. The completion register then holds P.
- R8: The next pointer is sampled at completion. If it is nonzero, the channel continues with that descriptor. If it is zero, the channel goes idle.
- R9: Once idle, a new head write restarts the channel on descriptors appended after the queue ended.
- R10: A completion-register write whose value differs from the held value sets the sticky mismatch flag. A matching write changes nothing, and no such write alters the held value.
- R11: Writing 1 to soft reset makes that register read 1 for exactly one cycle. At the end of that cycle the channel is idle, the completion register and the mismatch flag are 0, and an interrupted descriptor is not rewritten.
- R12: Clearing enable lets the current descriptor finish and be rewritten. The channel then goes idle even if the next pointer is nonzero, and the next descriptor stays owned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Host access this cycle |
| host_we | input | 1 | Host access is a write |
| host_addr | input | 12 | Host byte address (registers below 0x800, RAM from 0x800) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational |
| st_valid | output | 1 | Byte beat offered |
| st_ready | input | 1 | Byte beat accepted |
| st_addr | output | 32 | Byte address of the beat |
| st_sop | output | 1 | Beat starts a packet |
| st_eop | output | 1 | Beat ends a packet |

## Verification
The bench goes after the corner cases of the chain: an unowned descriptor, a zero-length buffer, a tail append that arrives after end of queue, and a head write made while busy or disabled. A design that checked ownership late would emit beats for a software-owned buffer. One that latched the next pointer at fetch rather than at completion would set end of queue wrongly. One that accepted head writes while running would jump chains mid-packet. Random back-pressure, held-off ready, disable mid-chain and a soft reset during a transfer test beat stability, the clean stop with the next descriptor left owned, and the absence of a stray writeback after reset.

// File: rtl/bdq_pkg.sv
package bdq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_XFER  = 2'd2,
        ST_WBACK = 2'd3
    } eng_state_e;

    localparam int MODE_SOP = 31;
    localparam int MODE_EOP = 30;
    localparam int MODE_OWN = 29;
    localparam int MODE_EOQ = 28;
    localparam int LEN_W    = 11;

    localparam logic [2:0] REG_CTRL = 3'd0;
    localparam logic [2:0] REG_SRST = 3'd1;
    localparam logic [2:0] REG_HEAD = 3'd2;
    localparam logic [2:0] REG_DONE = 3'd3;
    localparam logic [2:0] REG_STAT = 3'd4;
endpackage

// File: rtl/bdq_desc_ram.sv
module bdq_desc_ram #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                h_we,
    input  logic [AW-1:0]       h_idx,
    input  logic [31:0]         h_wdata,
    output logic [31:0]         h_rdata,
    input  logic [AW-1:0]       e_base,
    output logic [3:0][31:0]    e_rdata,
    input  logic                e_we,
    input  logic [AW-1:0]       e_idx,
    input  logic [31:0]         e_wdata
);
    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (h_we)
            mem[h_idx] <= h_wdata;
        else if (e_we)
            mem[e_idx] <= e_wdata;
    end

    assign h_rdata = mem[h_idx];

    for (genvar k = 0; k < 4; k++) begin : g_rd
        assign e_rdata[k] = mem[e_base + AW'(k)];
    end

    // R7
    wr_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(h_we && e_we));
endmodule

// File: rtl/bdq_regs.sv
module bdq_regs
    import bdq_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_sel,
    input  logic          h_we,
    input  logic [11:0]   h_addr,
    input  logic [31:0]   h_wdata,
    output logic [31:0]   h_rdata,
    input  logic [31:0]   ram_rdata,
    output logic          ram_we,
    output logic [AW-1:0] ram_idx,
    input  logic          busy,
    input  logic [31:0]   cur_ptr,
    input  logic          done,
    output logic          en,
    output logic          clr,
    output logic          start,
    output logic [31:0]   start_ptr
);
    logic        ram_hit, reg_hit, reg_wr;
    logic [2:0]  reg_idx;
    logic [31:0] done_q;
    logic        mis_q;

    assign ram_hit = h_addr[11] && ((h_addr[10:0] >> (AW + 2)) == 11'd0)
                     && (h_addr[1:0] == 2'b00);
    assign reg_hit = !h_addr[11] && (h_addr[10:5] == 6'd0) && (h_addr[1:0] == 2'b00);
    assign reg_idx = h_addr[4:2];
    assign reg_wr  = h_sel && h_we && reg_hit;
    assign ram_we  = h_sel && h_we && ram_hit;
    assign ram_idx = h_addr[AW+1:2];

    assign start     = reg_wr && (reg_idx == REG_HEAD) && !busy && en && !clr
                       && (h_wdata != 32'd0);
    assign start_ptr = h_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en     <= 1'b0;
            clr    <= 1'b0;
            done_q <= '0;
            mis_q  <= 1'b0;
        end else begin
            clr <= reg_wr && (reg_idx == REG_SRST) && h_wdata[0];
            if (reg_wr && (reg_idx == REG_CTRL))
                en <= h_wdata[0];
            if (clr) begin
                done_q <= '0;
                mis_q  <= 1'b0;
            end else begin
                if (done)
                    done_q <= cur_ptr;
                if (reg_wr && (reg_idx == REG_DONE) && (h_wdata != done_q))
                    mis_q <= 1'b1;
            end
        end
    end

    always_comb begin
        h_rdata = '0;
        if (ram_hit) begin
            h_rdata = ram_rdata;
        end else if (reg_hit) begin
            unique case (reg_idx)
                REG_CTRL: h_rdata = {31'd0, en};
                REG_SRST: h_rdata = {31'd0, clr};
                REG_HEAD: h_rdata = busy ? cur_ptr : 32'd0;
                REG_DONE: h_rdata = done_q;
                REG_STAT: h_rdata = {30'd0, busy, mis_q};
                default:  h_rdata = '0;
            endcase
        end
    end

    // R10
    mis_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mis_q && !clr) |=> mis_q);
    // R11
    srst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (done_q == 32'd0) && !mis_q);
endmodule

// File: rtl/bdq_engine.sv
module bdq_engine
    import bdq_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             start,
    input  logic [31:0]      start_ptr,
    input  logic             stall,
    input  logic [3:0][31:0] rd,
    output logic [AW-1:0]    rd_base,
    output logic             wr_en,
    output logic [AW-1:0]    wr_idx,
    output logic [31:0]      wr_data,
    output logic             busy,
    output logic [31:0]      cur_ptr,
    input  logic             st_ready,
    output logic             st_valid,
    output logic [31:0]      st_addr,
    output logic             st_sop,
    output logic             st_eop
);
    eng_state_e        state_q;
    logic [31:0]       cur_q, buf_q, mode_q;
    logic [LEN_W-1:0]  len_q, cnt_q;
    logic              last_beat, owned, next_zero;
    logic [LEN_W-1:0]  rd_len;
    logic              unused_bits;

    assign rd_len    = rd[2][LEN_W-1:0];
    assign owned     = rd[3][MODE_OWN];
    assign next_zero = (rd[0] == 32'd0);
    assign last_beat = (cnt_q == len_q - 1'b1);
    assign unused_bits = ^{rd[2][31:LEN_W], rd[3][LEN_W-1:0], rd[3][31:MODE_OWN+1],
                           rd[3][MODE_OWN-1:0], rd[1], mode_q[LEN_W-1:0],
                           mode_q[MODE_OWN:MODE_EOQ], cur_q[1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            buf_q   <= '0;
            mode_q  <= '0;
            len_q   <= '0;
            cnt_q   <= '0;
        end else if (clr) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cur_q   <= start_ptr;
                        state_q <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (owned) begin
                        buf_q   <= rd[1];
                        len_q   <= rd_len;
                        mode_q  <= rd[3];
                        cnt_q   <= '0;
                        state_q <= (rd_len == '0) ? ST_WBACK : ST_XFER;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_XFER: begin
                    if (st_ready) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (last_beat)
                            state_q <= ST_WBACK;
                    end
                end
                ST_WBACK: begin
                    if (!stall) begin
                        if (!next_zero && en) begin
                            cur_q   <= rd[0];
                            state_q <= ST_LOAD;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_base  = cur_q[AW+1:2];
        busy     = (state_q != ST_IDLE);
        cur_ptr  = cur_q;
        st_valid = (state_q == ST_XFER);
        st_addr  = buf_q + {{(32-LEN_W){1'b0}}, cnt_q};
        st_sop   = st_valid && (cnt_q == '0) && mode_q[MODE_SOP];
        st_eop   = st_valid && last_beat && mode_q[MODE_EOP];
        wr_en    = (state_q == ST_WBACK) && !stall;
        wr_idx   = cur_q[AW+1:2] + AW'(3);
        wr_data  = {mode_q[MODE_SOP], mode_q[MODE_EOP], 1'b0, next_zero,
                    mode_q[MODE_EOQ-1:LEN_W], len_q};
    end

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready && !clr) |=> st_valid && $stable(st_addr)
            && $stable(st_sop) && $stable(st_eop));
    // R3
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R4
    own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && !owned && !clr) |=> !busy);
    // R11
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !busy);
endmodule

// File: rtl/bdq_dma_chan.sv
module bdq_dma_chan #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_sel,
    input  logic        host_we,
    input  logic [11:0] host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        st_valid,
    input  logic        st_ready,
    output logic [31:0] st_addr,
    output logic        st_sop,
    output logic        st_eop
);
    logic             ram_we, e_we, busy, done, en, clr, start;
    logic [AW-1:0]    ram_idx, e_base, e_idx;
    logic [31:0]      ram_rdata, e_wdata, cur_ptr, start_ptr;
    logic [3:0][31:0] e_rdata;

    assign done = e_we;

    bdq_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .h_sel(host_sel), .h_we(host_we), .h_addr(host_addr),
        .h_wdata(host_wdata), .h_rdata(host_rdata),
        .ram_rdata(ram_rdata), .ram_we(ram_we), .ram_idx(ram_idx),
        .busy(busy), .cur_ptr(cur_ptr), .done(done),
        .en(en), .clr(clr), .start(start), .start_ptr(start_ptr)
    );

    bdq_desc_ram #(.DEPTH(DEPTH)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .h_we(ram_we), .h_idx(ram_idx), .h_wdata(host_wdata), .h_rdata(ram_rdata),
        .e_base(e_base), .e_rdata(e_rdata),
        .e_we(e_we), .e_idx(e_idx), .e_wdata(e_wdata)
    );

    bdq_engine #(.AW(AW)) u_eng (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(en),
        .start(start), .start_ptr(start_ptr), .stall(ram_we),
        .rd(e_rdata), .rd_base(e_base),
        .wr_en(e_we), .wr_idx(e_idx), .wr_data(e_wdata),
        .busy(busy), .cur_ptr(cur_ptr),
        .st_ready(st_ready), .st_valid(st_valid), .st_addr(st_addr),
        .st_sop(st_sop), .st_eop(st_eop)
    );
endmodule

// File: tb/tb_bdq_dma_chan.sv
module tb_bdq_dma_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0, host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        st_valid, st_ready = 1'b0, st_sop, st_eop;
    logic [31:0] st_addr;

    always #2 clk = ~clk;

    bdq_dma_chan dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_sop(st_sop), .st_eop(st_eop)
    );

    localparam logic [31:0] OWN = 32'h2000_0000, SOP = 32'h8000_0000,
                            EOP = 32'h4000_0000, EOQ = 32'h1000_0000;

    int n_chk = 0, n_fail = 0, cyc = 0, beats = 0;
    int rdy_mode = 1;
    logic [15:0] lfsr = 16'hACE1;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // behavioural reference
    logic [31:0] m_ram [64];
    int          m_st = 0;
    logic [31:0] m_cur = 0, m_buf = 0, m_mode = 0, m_cp = 0;
    int          m_len = 0, m_cnt = 0;
    bit          m_en = 0, m_mis = 0, m_srst = 0;

    function automatic logic [31:0] m_read(input logic [11:0] a);
        if (a[11]) return m_ram[a[7:2]];
        case (a[4:2])
            3'd0: return {31'd0, m_en};
            3'd1: return {31'd0, m_srst};
            3'd2: return (m_st != 0) ? m_cur : 32'd0;
            3'd3: return m_cp;
            3'd4: return {30'd0, m_st != 0, m_mis};
            default: return 32'd0;
        endcase
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_en = 0; m_mis = 0; m_srst = 0; m_cp = 0; m_cur = 0;
        end else begin : model_step
            bit hw, hram, exv, done_now;
            int idx, n_st;
            logic [31:0] nxt;
            // R5 R6: compare stream port every cycle
            exv = (m_st == 2);
            chk(st_valid == exv, "R5 valid", {31'd0, st_valid}, {31'd0, exv});
            if (exv) begin
                chk(st_addr == m_buf + m_cnt, "R5 addr", st_addr, m_buf + m_cnt);
                chk(st_sop == (m_cnt == 0 && m_mode[31]), "R5 sop", {31'd0, st_sop},
                    {31'd0, (m_cnt == 0 && m_mode[31])});
                chk(st_eop == (m_cnt == m_len - 1 && m_mode[30]), "R5 eop",
                    {31'd0, st_eop}, {31'd0, (m_cnt == m_len - 1 && m_mode[30])});
            end
            if (st_valid && st_ready) beats++;
            // R2: every host read against the reference
            if (host_sel && !host_we)
                chk(host_rdata == m_read(host_addr), "R2 read", host_rdata,
                    m_read(host_addr));
            hw   = host_sel && host_we;
            hram = hw && host_addr[11];
            idx  = m_cur[7:2];
            n_st = m_st;
            done_now = 0;
            if (m_srst) n_st = 0;
            else case (m_st)
                0: if (hw && host_addr == 12'h008 && m_en && host_wdata != 0) begin
                       m_cur = host_wdata; n_st = 1;
                   end
                1: if (m_ram[idx+3][29]) begin
                       m_buf = m_ram[idx+1]; m_len = m_ram[idx+2][10:0];
                       m_mode = m_ram[idx+3]; m_cnt = 0;
                       n_st = (m_len == 0) ? 3 : 2;
                   end else n_st = 0;
                2: if (st_ready) begin
                       if (m_cnt == m_len - 1) n_st = 3;
                       m_cnt++;
                   end
                default: if (!hram) begin
                       nxt = m_ram[idx];
                       m_ram[idx+3] = {m_mode[31:30], 1'b0, nxt == 0, m_mode[27:11],
                                       m_len[10:0]};
                       done_now = 1;
                       if (nxt != 0 && m_en) begin m_cur = nxt; n_st = 1; end
                       else n_st = 0;
                   end
            endcase
            if (m_srst) begin m_cp = 0; m_mis = 0; end
            else begin
                if (hw && host_addr == 12'h00C && host_wdata != m_cp) m_mis = 1;
                if (done_now) m_cp = m_cur_prev(m_cur, n_st, done_now, idx);
            end
            if (hw && host_addr == 12'h000) m_en = host_wdata[0];
            m_srst = hw && host_addr == 12'h004 && host_wdata[0];
            if (hram) m_ram[host_addr[7:2]] = host_wdata;
            m_st = n_st;
        end
    end

    // completion pointer is the descriptor just finished (word index idx)
    function automatic logic [31:0] m_cur_prev(input logic [31:0] c, input int s,
                                              input bit d, input int idx);
        if (d) return {24'd0, idx[5:0], 2'b00};
        return c ^ {31'd0, s[0]};
    endfunction

    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        st_ready = (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : lfsr[0];
    end

    task automatic hwr(input logic [11:0] a, input logic [31:0] d);
        host_sel = 1; host_we = 1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_sel = 0; host_we = 0;
    endtask

    task automatic hrd(input logic [11:0] a, output logic [31:0] d);
        host_sel = 1; host_we = 0; host_addr = a;
        @(negedge clk); d = host_rdata;
        @(posedge clk); #1;
        host_sel = 0;
    endtask

    task automatic put_desc(input int p, input logic [31:0] nx, input logic [31:0] b,
                            input logic [31:0] l, input logic [31:0] m);
        hwr(12'h800 + 12'(p), nx);
        hwr(12'h804 + 12'(p), b);
        hwr(12'h808 + 12'(p), l);
        hwr(12'h80C + 12'(p), m);
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 400; i++) begin
            hrd(12'h010, s);
            if (!s[1]) break;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        int b0;
        repeat (3) @(posedge clk);
        rst_n = 1;
        @(posedge clk); #1;
        // R2 reset values
        hrd(12'h000, d); chk(d == 0, "R2 ctrl reset", d, 0);
        hrd(12'h008, d); chk(d == 0, "R2 head reset", d, 0);
        hrd(12'h00C, d); chk(d == 0, "R2 done reset", d, 0);
        hrd(12'h010, d); chk(d == 0, "R2 status reset", d, 0);
        for (int i = 0; i < 64; i++) hwr(12'h800 + 12'(i * 4), 32'd0);
        hwr(12'h000, 32'd1);

        // R1 R5 R7 R8: two-descriptor chain under random ready
        rdy_mode = 0;
        put_desc(16'h10, 32'h20, 32'h1000, 3, SOP | OWN);
        put_desc(16'h20, 32'h00, 32'h2000, 5, EOP | OWN);
        b0 = beats;
        hwr(12'h008, 32'h10);
        hrd(12'h008, d); chk(d == 32'h10, "R3 head readback", d, 32'h10);
        wait_idle();
        chk(beats - b0 == 8, "R5 beat count", beats - b0, 8);
        hrd(12'h81C, d); chk(d == 32'h8000_0003, "R7 first mode", d, 32'h8000_0003);
        hrd(12'h82C, d); chk(d == 32'h5000_0005, "R7 R8 tail mode eoq", d, 32'h5000_0005);
        hrd(12'h00C, d); chk(d == 32'h20, "R7 completion ptr", d, 32'h20);
        hrd(12'h008, d); chk(d == 0, "R3 head idle zero", d, 0);

        // R4: unowned descriptor
        rdy_mode = 1;
        put_desc(16'h30, 0, 32'h3000, 2, SOP | EOP);
        b0 = beats;
        hwr(12'h008, 32'h30);
        wait_idle();
        chk(beats == b0, "R4 no beats", beats - b0, 0);
        hrd(12'h83C, d); chk(d == 32'hC000_0000, "R4 not rewritten", d, 32'hC000_0000);
        hrd(12'h00C, d); chk(d == 32'h20, "R4 completion kept", d, 32'h20);

        // R9: append after end of queue, zero-length tail (R5)
        rdy_mode = 0;
        put_desc(16'h40, 0, 32'h4000, 2, SOP | EOP | OWN);
        hwr(12'h008, 32'h40);
        wait_idle();
        put_desc(16'h50, 0, 32'h5000, 0, SOP | EOP | OWN);
        hwr(12'h840, 32'h50);
        hrd(12'h84C, d); chk(d == 32'hD000_0002, "R9 eoq seen", d, 32'hD000_0002);
        b0 = beats;
        if (d[28]) hwr(12'h008, 32'h50);
        wait_idle();
        chk(beats == b0, "R5 zero length", beats - b0, 0);
        hrd(12'h85C, d); chk(d == 32'hD000_0000, "R9 restarted tail", d, 32'hD000_0000);
        hrd(12'h00C, d); chk(d == 32'h50, "R9 completion", d, 32'h50);

        // R3: head writes while busy and while disabled are ignored
        rdy_mode = 1;
        put_desc(16'h60, 0, 32'h6000, 20, SOP | EOP | OWN);
        put_desc(16'h70, 0, 32'h7000, 1, SOP | EOP | OWN);
        hwr(12'h008, 32'h60);
        hwr(12'h008, 32'h70);
        wait_idle();
        hrd(12'h87C, d); chk(d == 32'hE000_0000, "R3 busy write ignored", d, 32'hE000_0000);
        hwr(12'h000, 32'd0);
        hwr(12'h008, 32'h70);
        hrd(12'h010, d); chk(d[1] == 0, "R3 disabled write ignored", d, 0);
        hwr(12'h000, 32'd1);

        // R12: disable mid-chain
        put_desc(16'h80, 32'h90, 32'h8000, 10, SOP | EOP | OWN);
        put_desc(16'h90, 0, 32'h9000, 1, SOP | EOP | OWN);
        hwr(12'h008, 32'h80);
        hwr(12'h000, 32'd0);
        wait_idle();
        hrd(12'h88C, d); chk(d == 32'hC000_000A, "R12 current finished", d, 32'hC000_000A);
        hrd(12'h89C, d); chk(d == 32'hE000_0000, "R12 next still owned", d, 32'hE000_0000);
        hrd(12'h008, d); chk(d == 0, "R12 head zero", d, 0);
        hwr(12'h000, 32'd1);

        // R10: completion acknowledge
        hwr(12'h00C, 32'h80);
        hrd(12'h010, d); chk(d[0] == 0, "R10 match no flag", d, 0);
        hwr(12'h00C, 32'h44);
        hrd(12'h010, d); chk(d[0] == 1, "R10 mismatch flag", d, 1);
        hwr(12'h00C, 32'h80);
        hrd(12'h010, d); chk(d[0] == 1, "R10 flag sticky", d, 1);
        hrd(12'h00C, d); chk(d == 32'h80, "R10 held value", d, 32'h80);

        // R6: ready held low
        put_desc(16'hB0, 0, 32'hB000, 4, SOP | EOP | OWN);
        rdy_mode = 2;
        hwr(12'h008, 32'hB0);
        repeat (6) @(posedge clk);
        #1;
        chk(st_valid && st_addr == 32'hB000 && st_sop, "R6 held beat", st_addr, 32'hB000);
        rdy_mode = 1;
        wait_idle();
        hrd(12'h8BC, d); chk(d == 32'hD000_0004, "R6 completes", d, 32'hD000_0004);

        // R11: soft reset mid-transfer
        put_desc(16'hA0, 0, 32'hA000, 30, SOP | EOP | OWN);
        hwr(12'h008, 32'hA0);
        repeat (3) @(posedge clk);
        #1;
        hwr(12'h004, 32'd1);
        hrd(12'h004, d); chk(d == 1, "R11 self-clear high", d, 1);
        hrd(12'h004, d); chk(d == 0, "R11 self-clear low", d, 0);
        hrd(12'h010, d); chk(d == 0, "R11 status cleared", d, 0);
        hrd(12'h00C, d); chk(d == 0, "R11 completion cleared", d, 0);
        hrd(12'h8AC, d); chk(d == 32'hE000_0000, "R11 no writeback", d, 32'hE000_0000);

        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule